// File: doc/BRIEF.md
# Sleep-Mode Clock Sequencer

This block puts a small processor core into one of two low-power states and brings it back out. A one-cycle pulse from the stop-instruction decoder selects the deep state, in which the oscillator, the PLL and every derived clock are turned off. A pulse from the wait-instruction decoder selects the light state, in which only the CPU and bus-interface clocks are gated. A control input decides whether the system clock and the divided peripheral clocks also stop in the light state.

A pending interrupt request ends either state, and so does reset. When the deep state ends on an interrupt and the stabilization option is set, the CPU and bus clocks stay off for a counted settling interval while the oscillator starts up again. With the option clear, they come back on the next cycle. While the core sleeps, a hold output tells the pin logic to keep the levels that the pins had when the sleep instruction ran. Every clock is modelled as an enable output.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: When `stop_req` is 1 in RUN and `irq_pend` is 0, the next state is STOP. If `stop_req` and `wait_req` are both 1, STOP wins.
- R2: When `wait_req` is 1 and `stop_req` is 0 in RUN, and `irq_pend` is 0, the next state is WAIT.
- R3: In STOP, `osc_en`, `pll_en`, `cpu_clk_en`, `bus_clk_en`, `sys_clk_en` and `presc_clk_en` are all 0.
- R4: In WAIT, `osc_en` is 1, `pll_en` equals `pll_keep`, and `cpu_clk_en` and `bus_clk_en` are 0.
- R5: In WAIT, `sys_clk_en` and `presc_clk_en` are both the inverse of `wait_sys_off`.
- R6: When `irq_pend` is 1 in WAIT, the state is RUN after the next edge, with all enables at 1.
- R7: When `irq_pend` is 1 in STOP and `stab_sel` is 0, the state is RUN after the next edge.
- R8: When `irq_pend` is 1 in STOP and `stab_sel` is 1, the block enters STOP_WAKE_DELAY. It stays there for exactly STAB_CYCLES cycles and then moves to RUN, and `irq_pend` has no effect during that time. In this state `osc_en`, `sys_clk_en` and `presc_clk_en` are 1, `pll_en` equals `pll_keep`, and `cpu_clk_en` and `bus_clk_en` are 0.
- R9: `pin_hold` is 1 in every state other than RUN and 0 in RUN.
- R10: A sleep pulse that arrives in the same cycle as `irq_pend`=1 leaves the block in RUN with no enable dropped.
- R11: A clock edge with `rst_n`=0 (synchronous, active-low) forces RUN with all enables at 1 and clears the settling counter. A settling interval that starts later lasts the full STAB_CYCLES.
- R12: `mode` encodes RUN=2'b00, WAIT=2'b01, STOP=2'b10, STOP_WAKE_DELAY=2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_req | input | 1 | One-cycle pulse from the stop instruction |
| wait_req | input | 1 | One-cycle pulse from the wait instruction |
| irq_pend | input | 1 | An interrupt request is pending |
| stab_sel | input | 1 | 1 = run the settling delay on wake from STOP |
| pll_keep | input | 1 | PLL enable setting used outside RUN and STOP |
| wait_sys_off | input | 1 | 1 = stop the system and prescaler clocks in WAIT |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| bus_clk_en | output | 1 | Bus-interface clock enable |
| sys_clk_en | output | 1 | System clock enable |
| presc_clk_en | output | 1 | Divided peripheral clock enable |
| pin_hold | output | 1 | Freeze pin states |
| mode | output | 2 | Current state code |

## Verification
The assertions assume that `stop_req` and `wait_req` come from a decoder that only raises them while the core is running. They also assume that the configuration inputs are held steady while the block is outside RUN. The bench changes `pll_keep`, `stab_sel` and `wait_sys_off` only between single-cycle steps whose outputs it checks against those same inputs. It pulses sleep requests in sleeping states only to show that they are ignored. Inside the settling interval it keeps `irq_pend` high on purpose, to show that the interval cannot be cut short.

// File: rtl/pwr_sleep_pkg.sv
// Package: shared state type of the sleep-mode sequencer.
// Assumes: the numeric codes are the mode port encoding (R12).
package pwr_sleep_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_WAIT  = 2'b01,
        ST_STOP  = 2'b10,
        ST_SETTL = 2'b11
    } pwr_state_t;
endpackage

// File: rtl/pwr_stab_timer.sv
// Settling timer: counts reference clocks while run is high and flags the
// last cycle of the interval. Assumes run stays high until done is seen.
module pwr_stab_timer #(
    parameter int STAB_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Count while running; clear at reset and whenever idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || done) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == LAST);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // R11
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/pwr_clk_decode.sv
// Clock-enable decoder: maps the sleep state and the configuration bits to
// the clock enables and the pin-hold flag. Purely combinational.
module pwr_clk_decode
    import pwr_sleep_pkg::*;
(
    input  pwr_state_t st,
    input  logic       pll_keep,
    input  logic       wait_sys_off,
    output logic       osc_en,
    output logic       pll_en,
    output logic       cpu_clk_en,
    output logic       bus_clk_en,
    output logic       sys_clk_en,
    output logic       presc_clk_en,
    output logic       pin_hold
);
    // Select the domain set that stays powered in each state.
    always_comb begin
        osc_en       = 1'b1;
        pll_en       = 1'b1;
        cpu_clk_en   = 1'b1;
        bus_clk_en   = 1'b1;
        sys_clk_en   = 1'b1;
        presc_clk_en = 1'b1;
        pin_hold     = 1'b0;
        unique case (st)
            ST_RUN: ;
            ST_WAIT: begin
                pll_en       = pll_keep;
                cpu_clk_en   = 1'b0;
                bus_clk_en   = 1'b0;
                sys_clk_en   = !wait_sys_off;
                presc_clk_en = !wait_sys_off;
                pin_hold     = 1'b1;
            end
            ST_STOP: begin
                osc_en       = 1'b0;
                pll_en       = 1'b0;
                cpu_clk_en   = 1'b0;
                bus_clk_en   = 1'b0;
                sys_clk_en   = 1'b0;
                presc_clk_en = 1'b0;
                pin_hold     = 1'b1;
            end
            ST_SETTL: begin
                pll_en     = pll_keep;
                cpu_clk_en = 1'b0;
                bus_clk_en = 1'b0;
                pin_hold   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pwr_sleep_ctrl.sv
// Sleep-mode sequencer top: holds the RUN/WAIT/STOP/settle state and steps
// it on sleep pulses, interrupts and the settling timer. Assumes sleep
// pulses come only while the core runs and the settings are stable in sleep.
module pwr_sleep_ctrl
    import pwr_sleep_pkg::*;
#(
    parameter int STAB_CYCLES = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic       wait_req,
    input  logic       irq_pend,
    input  logic       stab_sel,
    input  logic       pll_keep,
    input  logic       wait_sys_off,
    output logic       osc_en,
    output logic       pll_en,
    output logic       cpu_clk_en,
    output logic       bus_clk_en,
    output logic       sys_clk_en,
    output logic       presc_clk_en,
    output logic       pin_hold,
    output logic [1:0] mode
);
    pwr_state_t st_q, st_d;
    logic       stab_done;

    // Next-state choice; an interrupt beats a same-cycle sleep pulse.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (!irq_pend && stop_req)      st_d = ST_STOP;
                else if (!irq_pend && wait_req) st_d = ST_WAIT;
            end
            ST_WAIT:  if (irq_pend) st_d = ST_RUN;
            ST_STOP:  if (irq_pend) st_d = stab_sel ? ST_SETTL : ST_RUN;
            ST_SETTL: if (stab_done) st_d = ST_RUN;
            default:  st_d = ST_RUN;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    pwr_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q == ST_SETTL),
        .done  (stab_done)
    );

    pwr_clk_decode u_decode (
        .st           (st_q),
        .pll_keep     (pll_keep),
        .wait_sys_off (wait_sys_off),
        .osc_en       (osc_en),
        .pll_en       (pll_en),
        .cpu_clk_en   (cpu_clk_en),
        .bus_clk_en   (bus_clk_en),
        .sys_clk_en   (sys_clk_en),
        .presc_clk_en (presc_clk_en),
        .pin_hold     (pin_hold)
    );

    assign mode = st_q;

    // R1
    stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && stop_req && !irq_pend) |=> (mode == 2'b10));
    // R6
    wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && irq_pend) |=> (cpu_clk_en && bus_clk_en));
    // R7
    fast_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STOP && irq_pend && !stab_sel) |=> cpu_clk_en);
    // R8
    settle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STOP && irq_pend && stab_sel) |=> (!cpu_clk_en && osc_en));
    // R9
    hold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_hold) |-> $past(stop_req || wait_req));
    // R10
    irq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && irq_pend) |=> (mode == 2'b00));
endmodule

// File: tb/pwr_sleep_ctrl_test.sv
module pwr_sleep_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NSTAB = 16;
    localparam int NVEC = 11;
    // [14]stop [13]wait [12]irq [11]stab [10]pll [9]wsys [8:7]mode
    // [6:1]{osc,pll,cpu,bus,sys,presc} [0]hold
    localparam logic [14:0] VEC [0:NVEC-1] = '{
        15'b000000_00_111111_0,  // R11 idle run
        15'b010010_01_110011_1,  // R2 R4 R5 wait, pll kept, sys on
        15'b000001_01_100000_1,  // R4 R5 wait, pll off, sys off
        15'b001000_00_111111_0,  // R6 irq leaves wait
        15'b100000_10_000000_1,  // R1 R3 stop
        15'b001000_00_111111_0,  // R7 fast wake
        15'b101000_00_111111_0,  // R10 stop with irq
        15'b011000_00_111111_0,  // R10 wait with irq
        15'b110000_10_000000_1,  // R1 stop wins
        15'b010000_10_000000_1,  // R1 wait ignored in stop
        15'b001110_11_110011_1   // R8 R12 settle entry
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 0, wait_req = 0, irq_pend = 0;
    logic stab_sel = 0, pll_keep = 0, wait_sys_off = 0;
    logic osc_en, pll_en, cpu_clk_en, bus_clk_en, sys_clk_en, presc_clk_en, pin_hold;
    logic [1:0] mode;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_sleep_ctrl #(.STAB_CYCLES(NSTAB)) uut (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wait_req(wait_req),
        .irq_pend(irq_pend), .stab_sel(stab_sel), .pll_keep(pll_keep),
        .wait_sys_off(wait_sys_off), .osc_en(osc_en), .pll_en(pll_en),
        .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en), .sys_clk_en(sys_clk_en),
        .presc_clk_en(presc_clk_en), .pin_hold(pin_hold), .mode(mode)
    );

    function automatic logic [8:0] outs();
        return {mode, osc_en, pll_en, cpu_clk_en, bus_clk_en, sys_clk_en, presc_clk_en, pin_hold};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock step: inputs set at negedge, outputs sampled at next negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_in(input logic [5:0] v);
        {stop_req, wait_req, irq_pend, stab_sel, pll_keep, wait_sys_off} = v;
    endtask

    task automatic count_settle(input string req);
        int n = 1;
        irq_pend = 1'b1;  // R8 irq must not shorten the interval
        while (mode == 2'b11 && n < 1000) begin
            step();
            if (mode == 2'b11) n++;
        end
        irq_pend = 1'b0;
        check(req, n, NSTAB);
        check(req, outs(), 9'b00_111111_0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        step();
        rst_n = 1'b1;
        check("R11 reset state", outs(), 9'b00_111111_0);

        for (int i = 0; i < NVEC; i++) begin
            set_in(VEC[i][14:9]);
            step();
            check($sformatf("R12 vector %0d", i), outs(), VEC[i][8:0]);
        end
        set_in(6'b000110);
        count_settle("R8 settle length");

        // R11: reset in the middle of settling, then a full interval
        set_in(6'b100000); step();
        set_in(6'b001110); step();
        set_in(6'b000110);
        for (int k = 0; k < 5; k++) step();
        check("R8 still settling", mode, 2'b11);
        rst_n = 1'b0; step(); rst_n = 1'b1;
        check("R11 reset mid-settle", outs(), 9'b00_111111_0);
        set_in(6'b100000); step();
        set_in(6'b001110); step();
        set_in(6'b000110);
        count_settle("R11 counter cleared");

        // R9 hold in wait, R5 with sys clock kept
        set_in(6'b010000); step();
        set_in(6'b000000);
        check("R9 hold in wait", {pin_hold, sys_clk_en, pll_en}, 3'b110);
        set_in(6'b001000); step();
        check("R9 hold released", pin_hold, 1'b0);

        // R3 stop stays dark with no irq over many cycles
        set_in(6'b100110); step();
        set_in(6'b000110);
        for (int k = 0; k < 3; k++) step();
        check("R3 stop held", outs(), 9'b10_000000_1);
        set_in(6'b001010); step();
        check("R7 fast wake ignores pll_keep", outs(), 9'b00_111111_0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule